// File: doc/BRIEF.md
# Zero-turnaround synchronous SRAM core

This block is a synthesizable synchronous static RAM that takes a fresh read or write command on any clock edge, in any order, without an idle cycle between a read and a write. The address and control are registered on the rising edge. The data for a write arrives on a later edge: one edge after its command in flow-through mode and two edges after it in pipelined mode. The memory is built from 9-bit byte lanes, and each lane has its own write enable. A static mode input chooses between flow-through and pipelined read timing. A second static input chooses the order in which the two low address bits step during a burst.

When a command is registered, it opens a four-beat burst window. On each following edge, an advance input continues the burst with the next address in the sequence. A new command needs all three chip enables high. An output enable and a sleep input act on the data-output drivers without waiting for a clock edge. While sleep is high, no command is accepted. A write that has already been accepted still completes while sleep is high.

In pipelined mode, a read can arrive on the edge right after a write to the same word, before that write's data has reached the array. The core handles this by forwarding the late data into the output register, lane by lane, under the byte enables that were stored with the write.

Top module: `zt_sram`

## Requirements
- R1: While reset is active and in the cycles after it before any read, `dataOutEn` is 0 and `dataOut` is all zeros.
- R2: In flow-through mode (`pipeMode`=0), a read registered at edge n drives its word from just after edge n until edge n+1.
- R3: In pipelined mode (`pipeMode`=1), a read registered at edge n drives its word from just after edge n+1 until edge n+2, which is one cycle later than in flow-through mode.
- R4: The write data for a command registered at edge n is taken from `dataIn` at edge n+1 in flow-through mode and at edge n+2 in pipelined mode. `dataIn` on any other edge does not affect that write.
- R5: Byte lane l occupies bits [9l+8:9l]. Only the lanes whose `byteWrEn` bit is 1 when the command or burst beat is registered are written. The other lanes keep their contents.
- R6: A new command is registered only when `chipEn0`, `chipEn1` and `chipEn2` are all 1 and `advance` is 0. Otherwise, with no burst continuing, the edge is a deselect: nothing is written and no read data follows.
- R7: With `burstInterleave`=0, beat k of a burst (k=0..3, repeating) uses the base address with its two low bits replaced by (base+k) mod 4.
- R8: With `burstInterleave`=1, beat k uses the base address with its two low bits replaced by base XOR k.
- R9: In pipelined mode, a read registered on the edge right after a write to the same address returns, in each lane, the new data if that lane was enabled and the old contents if it was not.
- R10: When `outEnable` is 0, `dataOutEn` is 0 and `dataOut` is zero at once, with no clock edge needed.
- R11: When `sleep` is 1, the drivers are off at once and any command on that edge is ignored. A write registered before sleep still takes its data and completes.
- R12: `advance`=1 continues a burst even if a new command with all chip enables high is presented at the same time. The burst keeps its read or write direction. `advance`=1 with no burst open is a deselect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| pipeMode | input | 1 | Static: 1 selects pipelined reads, 0 selects flow-through |
| burstInterleave | input | 1 | Static: 1 selects interleaved burst order, 0 selects linear |
| addrIn | input | ADDR_W | Word address of a new command |
| writeCmd | input | 1 | 1 for a write command, 0 for a read |
| advance | input | 1 | Continue the open burst with its next beat |
| byteWrEn | input | LANES | Per-lane write enable, active high |
| chipEn0 | input | 1 | Chip enable, active high |
| chipEn1 | input | 1 | Chip enable, active high |
| chipEn2 | input | 1 | Chip enable, active high |
| dataIn | input | LANES*LANE_W | Late write data |
| outEnable | input | 1 | Asynchronous output-driver enable |
| sleep | input | 1 | Asynchronous power-down |
| dataOut | output | LANES*LANE_W | Read data, zero when not driven |
| dataOutEn | output | 1 | Output drivers enabled |

## Verification
Two events can fall on the same edge in pipelined mode:
- the late write data of one command landing in the array;
- the output register loading the read issued one edge after that write.

The bench provokes this by following a partial-lane write with a read of the same word. It also interleaves writes and reads to neighbouring words. It judges the result against a behavioural model. That model commits each pending write at its due edge before it evaluates any read due on that edge, so the expected word mixes new and old lanes. The asynchronous gates are also judged between edges, in the middle of a cycle in which read data is being driven.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;

  // Strobes from control to datapath, one cycle's worth
  typedef struct packed {
    logic wrEn;    // commit late write data this edge
    logic rdLive;  // flow-through read is being presented
    logic outLoad; // load output register this edge
    logic fwdHit;  // pending late write matches the read address
  } zt_strobe_t;

  // Low two address bits for burst beat cnt
  function automatic logic [1:0] burstLow(input logic [1:0] base,
                                          input logic [1:0] cnt,
                                          input logic interleave);
    burstLow = interleave ? (base ^ cnt) : (base + cnt);
  endfunction

endpackage

// File: rtl/zt_sram_ctrl.sv
module zt_sram_ctrl
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipeMode,
  input  logic              burstInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              writeCmd,
  input  logic              advance,
  input  logic [LANES-1:0]  byteWrEn,
  input  logic              allCe,
  input  logic              sleep,
  output zt_strobe_t        strobe,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrBe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [LANES-1:0]  fwdBe
);

  // Registered command (first stage)
  logic              cmdValid;
  logic              cmdWrite;
  logic [ADDR_W-1:0] cmdAddr;
  logic [LANES-1:0]  cmdBe;
  // Burst state
  logic              burstOn;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        burstCnt;
  // Second stage, used for pipelined late writes
  logic              lateValid;
  logic [ADDR_W-1:0] lateAddr;
  logic [LANES-1:0]  lateBe;

  logic [1:0]        nextCnt;
  logic [ADDR_W-1:0] nextAddr;

  always_comb begin
    nextCnt  = burstCnt + 2'd1;
    nextAddr = baseAddr;
    nextAddr[1:0] = burstLow(baseAddr[1:0], nextCnt, burstInterleave);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdValid  <= 1'b0;
      burstOn   <= 1'b0;
      lateValid <= 1'b0;
    end else begin
      lateValid <= cmdValid & cmdWrite;
      lateAddr  <= cmdAddr;
      lateBe    <= cmdBe;
      if (sleep) begin
        cmdValid <= 1'b0;
        burstOn  <= 1'b0;
      end else if (advance && burstOn) begin
        cmdValid <= 1'b1;
        cmdAddr  <= nextAddr;
        burstCnt <= nextCnt;
        cmdBe    <= byteWrEn;
      end else if (allCe && !advance) begin
        cmdValid <= 1'b1;
        cmdWrite <= writeCmd;
        cmdAddr  <= addrIn;
        baseAddr <= addrIn;
        burstCnt <= 2'd0;
        cmdBe    <= byteWrEn;
        burstOn  <= 1'b1;
      end else begin
        cmdValid <= 1'b0;
        burstOn  <= 1'b0;
      end
    end
  end

  logic readNow;
  assign readNow = cmdValid & ~cmdWrite;

  always_comb begin
    strobe.wrEn    = pipeMode ? lateValid : (cmdValid & cmdWrite);
    strobe.rdLive  = ~pipeMode & readNow;
    strobe.outLoad = pipeMode & readNow;
    strobe.fwdHit  = pipeMode & lateValid & readNow & (lateAddr == cmdAddr);
    wrAddr         = pipeMode ? lateAddr : cmdAddr;
    wrBe           = pipeMode ? lateBe : cmdBe;
    rdAddr         = cmdAddr;
    fwdBe          = lateBe;
  end

endmodule

// File: rtl/zt_sram_dp.sv
module zt_sram_dp
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pipeMode,
  input  zt_strobe_t              strobe,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [LANES-1:0]        wrBe,
  input  logic [ADDR_W-1:0]       rdAddr,
  input  logic [LANES-1:0]        fwdBe,
  input  logic [LANES*LANE_W-1:0] dataIn,
  output logic [LANES*LANE_W-1:0] rdData,
  output logic                    rdValid
);

  localparam int DEPTH  = 1 << ADDR_W;
  localparam int DATA_W = LANES * LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] arrayWord;
  logic [DATA_W-1:0] mergedWord;
  logic [DATA_W-1:0] outReg;
  logic              outValid;

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int l = 0; l < LANES; l++) begin
        if (wrBe[l]) mem[wrAddr][l*LANE_W +: LANE_W] <= dataIn[l*LANE_W +: LANE_W];
      end
    end
  end

  assign arrayWord = mem[rdAddr];

  // Lane-wise forwarding of late write data that lands this edge
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign mergedWord[g*LANE_W +: LANE_W] = (strobe.fwdHit && fwdBe[g])
        ? dataIn[g*LANE_W +: LANE_W] : arrayWord[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= strobe.outLoad;
    if (strobe.outLoad) outReg <= mergedWord;
  end

  assign rdData  = pipeMode ? outReg : arrayWord;
  assign rdValid = pipeMode ? outValid : strobe.rdLive;

endmodule

// File: rtl/zt_sram.sv
module zt_sram
  import zt_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pipeMode,
  input  logic              burstInterleave,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              writeCmd,
  input  logic              advance,
  input  logic [LANES-1:0]  byteWrEn,
  input  logic              chipEn0,
  input  logic              chipEn1,
  input  logic              chipEn2,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              outEnable,
  input  logic              sleep,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOutEn
);

  zt_strobe_t        strobe;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  logic [LANES-1:0]  wrBe;
  logic [LANES-1:0]  fwdBe;
  logic [DATA_W-1:0] rdData;
  logic              rdValid;

  zt_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pipeMode(pipeMode),
    .burstInterleave(burstInterleave), .addrIn(addrIn), .writeCmd(writeCmd),
    .advance(advance), .byteWrEn(byteWrEn),
    .allCe(chipEn0 & chipEn1 & chipEn2), .sleep(sleep),
    .strobe(strobe), .wrAddr(wrAddr), .wrBe(wrBe), .rdAddr(rdAddr), .fwdBe(fwdBe)
  );

  zt_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .pipeMode(pipeMode), .strobe(strobe),
    .wrAddr(wrAddr), .wrBe(wrBe), .rdAddr(rdAddr), .fwdBe(fwdBe),
    .dataIn(dataIn), .rdData(rdData), .rdValid(rdValid)
  );

  // Asynchronous driver gating
  assign dataOutEn = rdValid & outEnable & ~sleep;
  assign dataOut   = dataOutEn ? rdData : '0;

endmodule

// File: rtl/zt_sram_chk.sv
module zt_sram_chk #(
  parameter int DATA_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pipeMode,
  input logic              advance,
  input logic              chipEn0,
  input logic              chipEn1,
  input logic              chipEn2,
  input logic              outEnable,
  input logic              sleep,
  input logic [DATA_W-1:0] dataOut,
  input logic              dataOutEn
);

  logic allCe;
  assign allCe = chipEn0 & chipEn1 & chipEn2;

  // R10
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !outEnable |-> !dataOutEn);

  // R11
  sleep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dataOutEn);

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dataOutEn |-> dataOut == '0);

  // R6
  desel_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipeMode && !advance && !allCe) |=> !dataOutEn);

  // R3
  desel_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pipeMode && !advance && !allCe) |=> ##1 !dataOutEn);

  // R11
  sleep_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipeMode && sleep) |=> !dataOutEn);

endmodule

bind zt_sram zt_sram_chk #(.DATA_W(DATA_W)) u_zt_sram_chk (
  .clk(clk), .rst_n(rst_n), .pipeMode(pipeMode), .advance(advance),
  .chipEn0(chipEn0), .chipEn1(chipEn1), .chipEn2(chipEn2),
  .outEnable(outEnable), .sleep(sleep), .dataOut(dataOut), .dataOutEn(dataOutEn)
);

// File: tb/test_zt_sram.sv
module test_zt_sram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rst_n, pipeMode, burstInterleave, writeCmd, advance;
  logic chipEn0, chipEn1, chipEn2, outEnable, sleep, dataOutEn;
  logic [AW-1:0] addrIn;
  logic [1:0]    byteWrEn;
  logic [DW-1:0] dataIn, dataOut;

  zt_sram i_zt_sram (
    .clk(clk), .rst_n(rst_n), .pipeMode(pipeMode), .burstInterleave(burstInterleave),
    .addrIn(addrIn), .writeCmd(writeCmd), .advance(advance), .byteWrEn(byteWrEn),
    .chipEn0(chipEn0), .chipEn1(chipEn1), .chipEn2(chipEn2), .dataIn(dataIn),
    .outEnable(outEnable), .sleep(sleep), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  string curReq = "R1";

  // Reference model state
  logic [DW-1:0] mMem [int];
  int   pAddr[$];
  logic [1:0] pBe[$];
  int   pDue[$];
  int   rAddr[$];
  int   rDue[$];
  int   edgeNo = 0;
  bit   mBurstOn = 0;
  bit   mBurstW = 0;
  int   mBase = 0;
  int   mCnt = 0;
  bit   expValid = 0;
  logic [DW-1:0] expData = '0;

  task automatic check(input string req, input string what, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic modelEdge();
    int a;
    bit cv;
    bit w;
    edgeNo++;
    if (!rst_n) begin
      pAddr.delete(); pBe.delete(); pDue.delete(); rAddr.delete(); rDue.delete();
      mBurstOn = 0; expValid = 0;
      return;
    end
    while (pDue.size() > 0 && pDue[0] == edgeNo) begin
      logic [DW-1:0] word;
      int wa;
      logic [1:0] be;
      wa = pAddr.pop_front(); be = pBe.pop_front(); void'(pDue.pop_front());
      word = mMem.exists(wa) ? mMem[wa] : 'x;
      if (be[0]) word[8:0]  = dataIn[8:0];
      if (be[1]) word[17:9] = dataIn[17:9];
      mMem[wa] = word;
    end
    cv = 0; w = 0; a = 0;
    if (sleep) mBurstOn = 0;
    else if (advance && mBurstOn) begin
      int low;
      mCnt = (mCnt + 1) % 4;
      low = burstInterleave ? ((mBase % 4) ^ mCnt) : ((mBase + mCnt) % 4);
      a = mBase - (mBase % 4) + low; cv = 1; w = mBurstW;
    end else if (chipEn0 && chipEn1 && chipEn2 && !advance) begin
      mBase = int'(addrIn); mCnt = 0; a = mBase; w = writeCmd; mBurstW = writeCmd;
      cv = 1; mBurstOn = 1;
    end else mBurstOn = 0;
    if (cv) begin
      if (w) begin
        pAddr.push_back(a); pBe.push_back(byteWrEn); pDue.push_back(edgeNo + (pipeMode ? 2 : 1));
      end else begin
        rAddr.push_back(a); rDue.push_back(edgeNo + (pipeMode ? 1 : 0));
      end
    end
    expValid = 0;
    if (rDue.size() > 0 && rDue[0] == edgeNo) begin
      int ra;
      ra = rAddr.pop_front(); void'(rDue.pop_front());
      expValid = 1;
      expData = mMem.exists(ra) ? mMem[ra] : 'x;
    end
  endtask

  task automatic compareNow();
    bit en;
    en = expValid && outEnable && !sleep;
    check(curReq, "dataOutEn", {17'd0, dataOutEn}, {17'd0, en});
    check(curReq, "dataOut", dataOut, en ? expData : '0);
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareNow();
  endtask

  task automatic cmdCe(input bit w, input int a, input logic [1:0] be,
                       input logic [DW-1:0] d, input logic [2:0] ces);
    {chipEn2, chipEn1, chipEn0} = ces;
    advance = 0; writeCmd = w; addrIn = AW'(a); byteWrEn = be; dataIn = d;
    tick();
  endtask

  task automatic cmdW(input int a, input logic [1:0] be, input logic [DW-1:0] d);
    cmdCe(1, a, be, d, 3'b111);
  endtask

  task automatic cmdR(input int a, input logic [DW-1:0] d);
    cmdCe(0, a, 2'b00, d, 3'b111);
  endtask

  // Burst beat; a competing new command is presented as a distractor (R12)
  task automatic burst(input logic [1:0] be, input logic [DW-1:0] d);
    {chipEn2, chipEn1, chipEn0} = 3'b111;
    advance = 1; writeCmd = 1; addrIn = 8'h77; byteWrEn = be; dataIn = d;
    tick();
  endtask

  task automatic idle(input logic [DW-1:0] d);
    {chipEn2, chipEn1, chipEn0} = 3'b000;
    advance = 0; writeCmd = 0; byteWrEn = 2'b00; dataIn = d;
    tick();
  endtask

  task automatic doReset();
    rst_n = 0;
    for (int i = 0; i < 3; i++) idle('0);
    rst_n = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", edgeNo);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    pipeMode = 0; burstInterleave = 0; outEnable = 1; sleep = 0;
    rst_n = 0; advance = 0; writeCmd = 0; addrIn = '0; byteWrEn = '0; dataIn = '0;
    {chipEn2, chipEn1, chipEn0} = 3'b000;
    @(negedge clk);

    // ---- flow-through, linear order ----
    curReq = "R1";
    doReset();
    idle('0); idle('0);

    curReq = "R2";   // and R4: data taken one edge after the command
    cmdW(8, 2'b11, 18'h3FFFF);
    cmdR(8, 18'h1A5A5);
    idle('0); idle('0);

    curReq = "R5";
    cmdW(8, 2'b01, '0);
    cmdR(8, 18'h3FFFF);
    idle('0);

    curReq = "R6";
    cmdCe(1, 8, 2'b11, '0, 3'b101);
    idle(18'h00000);
    cmdCe(0, 8, 2'b00, '0, 3'b011);
    cmdCe(0, 8, 2'b00, '0, 3'b110);
    cmdR(8, '0);
    idle('0);

    curReq = "R7";
    cmdW(8'h12, 2'b11, '0);
    burst(2'b11, 18'h10000);
    burst(2'b11, 18'h10011);
    burst(2'b11, 18'h10022);
    idle(18'h10033);
    cmdR(8'h12, '0);
    burst(2'b00, '0); burst(2'b00, '0); burst(2'b00, '0);
    idle('0);

    curReq = "R12";
    advance = 1; {chipEn2, chipEn1, chipEn0} = 3'b111; writeCmd = 1; addrIn = 8'd8;
    byteWrEn = 2'b11; dataIn = 18'h2AAAA;
    tick();
    idle(18'h2AAAA);
    cmdR(8, '0);
    idle('0);

    curReq = "R10";
    cmdR(8'h12, '0);
    outEnable = 0; #1;
    check("R10", "dataOutEn mid-cycle", {17'd0, dataOutEn}, '0);
    check("R10", "dataOut mid-cycle", dataOut, '0);
    outEnable = 1; #1;
    check("R10", "dataOutEn restored", {17'd0, dataOutEn}, 18'd1);
    outEnable = 0;
    cmdR(8'h13, '0);
    outEnable = 1;
    idle('0);

    curReq = "R11";
    cmdW(8'h20, 2'b11, '0);
    sleep = 1;
    cmdW(8, 2'b11, 18'h2BEEF);
    cmdR(8'h20, '0);
    sleep = 0;
    cmdR(8'h20, '0);
    cmdR(8, '0);
    sleep = 1; #1;
    check("R11", "dataOutEn under sleep", {17'd0, dataOutEn}, '0);
    sleep = 0;
    idle('0);

    // ---- pipelined, interleaved order ----
    pipeMode = 1; burstInterleave = 1;
    curReq = "R1";
    doReset();
    idle('0);

    curReq = "R3";   // and R4: data taken two edges after the command
    cmdW(8'h30, 2'b11, '0);
    idle(18'h01111);
    idle(18'h0ABCD);
    cmdR(8'h30, '0);
    idle('0); idle('0);

    curReq = "R9";
    cmdW(8'h30, 2'b10, '0);
    cmdR(8'h30, '0);
    idle(18'h25555);
    idle('0); idle('0);
    cmdW(8'h31, 2'b11, '0);
    cmdR(8'h30, '0);
    cmdW(8'h32, 2'b11, 18'h13131);
    cmdR(8'h31, 18'h3F3F3);
    idle(18'h23232);
    cmdR(8'h32, '0);
    idle('0); idle('0);

    curReq = "R8";
    cmdW(8'h41, 2'b11, '0);
    burst(2'b11, '0);
    burst(2'b11, 18'h20001);
    burst(2'b11, 18'h20002);
    idle(18'h20003);
    idle(18'h20004);
    cmdR(8'h41, '0);
    burst(2'b00, '0); burst(2'b00, '0); burst(2'b00, '0);
    idle('0); idle('0);

    curReq = "R12";
    cmdR(8'h40, '0);
    burst(2'b00, '0);
    idle('0); idle('0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule